// File: doc/BRIEF.md
# Early Integer Execution Stage

This stage follows the register-file read in an in-order front-end. Each cycle it receives one decode group of four instruction slots. Each slot carries an opcode, two operand values with ready flags, the physical tags of both sources and the destination tag. Single-cycle integer operations whose operands are already known are executed here on a small pool of ALUs. Their results go out on a write port that belongs to this stage alone. Such instructions are marked done, so the out-of-order back-end does not need to queue them.

The stage is opportunistic and never holds the group back. An instruction that is not a candidate, lacks an operand, or finds every ALU taken moves on unexecuted, one cycle later, like a no-op through the units. The stage also has a local forwarding path with one rule: an instruction may take at most one missing operand from the results this stage produced for the group of the cycle before. A bubble cycle breaks that chain.

Top module: `preexec_stage`

## Requirements
- R1: Opcodes 0 to 10 are candidates (0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 signed set-less-than, 9 unsigned set-less-than, 10 address add base plus immediate). Opcodes 11 to 15 stand for multi-cycle, floating-point and other work and are never executed here.
- R2: An executed instruction's result equals its operation applied to operand A and operand B. Shifts use the low log2(XLEN) bits of B, and set-less-than yields 1 or 0.
- R3: An instruction is executed only if both operands were ready at the register read, or exactly one was missing and the local bypass supplies it. With both missing it is never executed.
- R4: The bypass matches a missing source tag only against results this stage wrote in the immediately preceding cycle. A B operand flagged as an immediate counts as ready.
- R5: At most NUM_ALU (2) instructions execute per group, and the ALUs go to eligible slots in ascending slot order (slot 0 first).
- R6: The stage never stalls. Every slot is presented one cycle after it was accepted, with its valid flag, opcode and destination tag unchanged. Slots that are not executed have done at 0.
- R7: Write-port lane k carries the destination tag and result of the k-th executed slot of the group. It appears in the same cycle as that slot's done flag, and unused lanes have their enable at 0.
- R8: During reset, all output valid flags, done flags and write enables are 0.
- R9: A slot whose valid input is 0 is never executed and is not presented as valid.
- R10: A slot that has its operands complete through the bypass but gets no ALU passes on with the forwarded value in its operand and that operand's ready flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | SLOTS | Slot holds an instruction |
| in_op | input | SLOTS*4 | Opcode per slot |
| in_a | input | SLOTS*XLEN | Operand A value per slot |
| in_b | input | SLOTS*XLEN | Operand B value or immediate per slot |
| in_rdy_a | input | SLOTS | Operand A was read as a computed value |
| in_rdy_b | input | SLOTS | Operand B was read as a computed value |
| in_b_imm | input | SLOTS | Operand B is an immediate |
| in_tag_a | input | SLOTS*TAGW | Physical tag of source A |
| in_tag_b | input | SLOTS*TAGW | Physical tag of source B |
| in_dst | input | SLOTS*TAGW | Destination physical tag |
| out_valid | output | SLOTS | Slot presented downstream |
| out_done | output | SLOTS | Slot was executed here |
| out_op | output | SLOTS*4 | Opcode passed through |
| out_a | output | SLOTS*XLEN | Operand A, forwarded value if applied |
| out_b | output | SLOTS*XLEN | Operand B, forwarded value if applied |
| out_rdy_a | output | SLOTS | Operand A known |
| out_rdy_b | output | SLOTS | Operand B known |
| out_dst | output | SLOTS*TAGW | Destination tag passed through |
| out_result | output | SLOTS*XLEN | Result of an executed slot, else 0 |
| wb_en | output | NUM_ALU | Write-port lane enable |
| wb_tag | output | NUM_ALU*TAGW | Write-port lane destination tag |
| wb_data | output | NUM_ALU*XLEN | Write-port lane data |

## Verification
The assertions rely on the producer giving each in-flight instruction its own destination tag, so that at most one write-port lane can match a source tag. The directed groups always use distinct destination tags within any two consecutive cycles. The assertions also expect the input slots to be quiet while reset is held. The bench drives all inputs to 0 until reset is released, and it changes inputs only just after a clock edge.

// File: rtl/preexec_stage.sv
module preexec_stage #(
  parameter int SLOTS   = 4,
  parameter int NUM_ALU = 2,
  parameter int XLEN    = 32,
  parameter int TAGW    = 7
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        in_valid,
  input  logic [SLOTS*4-1:0]      in_op,
  input  logic [SLOTS*XLEN-1:0]   in_a,
  input  logic [SLOTS*XLEN-1:0]   in_b,
  input  logic [SLOTS-1:0]        in_rdy_a,
  input  logic [SLOTS-1:0]        in_rdy_b,
  input  logic [SLOTS-1:0]        in_b_imm,
  input  logic [SLOTS*TAGW-1:0]   in_tag_a,
  input  logic [SLOTS*TAGW-1:0]   in_tag_b,
  input  logic [SLOTS*TAGW-1:0]   in_dst,
  output logic [SLOTS-1:0]        out_valid,
  output logic [SLOTS-1:0]        out_done,
  output logic [SLOTS*4-1:0]      out_op,
  output logic [SLOTS*XLEN-1:0]   out_a,
  output logic [SLOTS*XLEN-1:0]   out_b,
  output logic [SLOTS-1:0]        out_rdy_a,
  output logic [SLOTS-1:0]        out_rdy_b,
  output logic [SLOTS*TAGW-1:0]   out_dst,
  output logic [SLOTS*XLEN-1:0]   out_result,
  output logic [NUM_ALU-1:0]      wb_en,
  output logic [NUM_ALU*TAGW-1:0] wb_tag,
  output logic [NUM_ALU*XLEN-1:0] wb_data
);
  localparam int SHW   = $clog2(XLEN);
  localparam int LANEW = $clog2(NUM_ALU + 1);
  localparam logic [3:0] LAST_CAND = 4'd10;

  function automatic logic [XLEN-1:0] alu(input logic [3:0] op,
                                          input logic [XLEN-1:0] x,
                                          input logic [XLEN-1:0] y);
    logic [SHW-1:0] sh;
    sh = y[SHW-1:0];
    case (op)
      4'd0, 4'd10: alu = x + y;
      4'd1:        alu = x - y;
      4'd2:        alu = x & y;
      4'd3:        alu = x | y;
      4'd4:        alu = x ^ y;
      4'd5:        alu = x << sh;
      4'd6:        alu = x >> sh;
      4'd7:        alu = XLEN'($signed(x) >>> sh);
      4'd8:        alu = XLEN'($signed(x) < $signed(y));
      4'd9:        alu = XLEN'(x < y);
      default:     alu = '0;
    endcase
  endfunction

  logic [SLOTS-1:0] opnd_ok, elig, grant, rdy_a_eff, rdy_b_eff;
  logic [XLEN-1:0]  a_eff [SLOTS];
  logic [XLEN-1:0]  b_eff [SLOTS];
  logic [XLEN-1:0]  res   [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [3:0]      op;
    logic            hit_a, hit_b, b_rf;
    logic [XLEN-1:0] byp_a, byp_b;

    assign op   = in_op[g*4 +: 4];
    assign b_rf = in_rdy_b[g] | in_b_imm[g];

    always_comb begin
      hit_a = 1'b0; byp_a = '0;
      hit_b = 1'b0; byp_b = '0;
      for (int k = 0; k < NUM_ALU; k++) begin
        if (wb_en[k] && wb_tag[k*TAGW +: TAGW] == in_tag_a[g*TAGW +: TAGW]) begin
          hit_a = 1'b1; byp_a = wb_data[k*XLEN +: XLEN];
        end
        if (wb_en[k] && wb_tag[k*TAGW +: TAGW] == in_tag_b[g*TAGW +: TAGW]) begin
          hit_b = 1'b1; byp_b = wb_data[k*XLEN +: XLEN];
        end
      end
    end

    assign opnd_ok[g]   = (in_rdy_a[g] && b_rf) ||
                          (!in_rdy_a[g] && hit_a && b_rf) ||
                          (in_rdy_a[g] && !b_rf && hit_b);
    assign a_eff[g]     = (opnd_ok[g] && !in_rdy_a[g]) ? byp_a : in_a[g*XLEN +: XLEN];
    assign b_eff[g]     = (opnd_ok[g] && !b_rf) ? byp_b : in_b[g*XLEN +: XLEN];
    assign rdy_a_eff[g] = in_rdy_a[g] | opnd_ok[g];
    assign rdy_b_eff[g] = in_rdy_b[g] | opnd_ok[g];
    assign elig[g]      = in_valid[g] && op <= LAST_CAND && opnd_ok[g];
    assign res[g]       = alu(op, a_eff[g], b_eff[g]);

    // R1
    cand_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_done[g] |-> out_op[g*4 +: 4] <= LAST_CAND);
  end

  logic [NUM_ALU-1:0]      nxt_en;
  logic [NUM_ALU*TAGW-1:0] nxt_tag;
  logic [NUM_ALU*XLEN-1:0] nxt_data;
  logic [LANEW-1:0]        used;

  always_comb begin
    grant = '0; used = '0;
    nxt_en = '0; nxt_tag = '0; nxt_data = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (elig[s] && used < LANEW'(NUM_ALU)) begin
        grant[s] = 1'b1;
        for (int k = 0; k < NUM_ALU; k++) begin
          if (LANEW'(k) == used) begin
            nxt_en[k] = 1'b1;
            nxt_tag[k*TAGW +: TAGW]  = in_dst[s*TAGW +: TAGW];
            nxt_data[k*XLEN +: XLEN] = res[s];
          end
        end
        used = used + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0; out_done <= '0; out_op <= '0;
      out_a <= '0; out_b <= '0; out_rdy_a <= '0; out_rdy_b <= '0;
      out_dst <= '0; out_result <= '0;
      wb_en <= '0; wb_tag <= '0; wb_data <= '0;
    end else begin
      out_valid <= in_valid;
      out_done  <= grant;
      out_op    <= in_op;
      out_dst   <= in_dst;
      out_rdy_a <= rdy_a_eff;
      out_rdy_b <= rdy_b_eff;
      for (int s = 0; s < SLOTS; s++) begin
        out_a[s*XLEN +: XLEN]      <= a_eff[s];
        out_b[s*XLEN +: XLEN]      <= b_eff[s];
        out_result[s*XLEN +: XLEN] <= grant[s] ? res[s] : '0;
      end
      wb_en   <= nxt_en;
      wb_tag  <= nxt_tag;
      wb_data <= nxt_data;
    end
  end

  // R5
  alu_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_done) <= NUM_ALU);

  // R7
  lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wb_en) == $countones(out_done));

  // R9
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done & ~out_valid) == '0);

  // R6
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R8
  always_ff @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (out_valid == '0 && wb_en == '0);
  end
endmodule

// File: tb/sim_preexec_stage.sv
`timescale 1ns/1ps
module sim_preexec_stage;
  localparam int S = 4, NA = 2, XL = 32, TW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [S-1:0] in_valid, in_rdy_a, in_rdy_b, in_b_imm;
  logic [S*4-1:0] in_op;
  logic [S*XL-1:0] in_a, in_b;
  logic [S*TW-1:0] in_tag_a, in_tag_b, in_dst;
  logic [S-1:0] out_valid, out_done, out_rdy_a, out_rdy_b;
  logic [S*4-1:0] out_op;
  logic [S*XL-1:0] out_a, out_b, out_result;
  logic [S*TW-1:0] out_dst;
  logic [NA-1:0] wb_en;
  logic [NA*TW-1:0] wb_tag;
  logic [NA*XL-1:0] wb_data;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  preexec_stage #(.SLOTS(S), .NUM_ALU(NA), .XLEN(XL), .TAGW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .in_rdy_a(in_rdy_a), .in_rdy_b(in_rdy_b), .in_b_imm(in_b_imm),
    .in_tag_a(in_tag_a), .in_tag_b(in_tag_b), .in_dst(in_dst),
    .out_valid(out_valid), .out_done(out_done), .out_op(out_op), .out_a(out_a),
    .out_b(out_b), .out_rdy_a(out_rdy_a), .out_rdy_b(out_rdy_b), .out_dst(out_dst),
    .out_result(out_result), .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_group();
    in_valid = '0; in_rdy_a = '0; in_rdy_b = '0; in_b_imm = '0;
    in_op = '0; in_a = '0; in_b = '0; in_tag_a = '0; in_tag_b = '0; in_dst = '0;
  endtask

  task automatic put(input int s, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic ra, input logic rb,
                     input logic imm, input logic [TW-1:0] ta,
                     input logic [TW-1:0] tb, input logic [TW-1:0] dst);
    in_valid[s] = 1'b1; in_op[s*4 +: 4] = op;
    in_a[s*XL +: XL] = a; in_b[s*XL +: XL] = b;
    in_rdy_a[s] = ra; in_rdy_b[s] = rb; in_b_imm[s] = imm;
    in_tag_a[s*TW +: TW] = ta; in_tag_b[s*TW +: TW] = tb; in_dst[s*TW +: TW] = dst;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] res_of(input int s);
    return out_result[s*XL +: XL];
  endfunction

  task automatic t_reset();
    clear_group();
    repeat (3) @(posedge clk);
    #1;
    check("R8 valid in reset", 32'(out_valid), 0);
    check("R8 done in reset", 32'(out_done), 0);
    check("R8 wb_en in reset", 32'(wb_en), 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_alloc();
    clear_group();
    put(0, 4'd0, 5, 7, 1, 1, 0, 0, 0, 7'd1);
    put(1, 4'd1, 3, 10, 1, 1, 0, 0, 0, 7'd2);
    put(2, 4'd2, 32'hF, 32'h3, 1, 1, 0, 0, 0, 7'd3);
    put(3, 4'd4, 1, 1, 1, 1, 0, 0, 0, 7'd4);
    step();
    check("R5 done only first two", 32'(out_done), 32'b0011);
    check("R2 add", res_of(0), 12);
    check("R2 sub", res_of(1), 32'hFFFF_FFF9);
    check("R6 all slots valid", 32'(out_valid), 32'b1111);
    check("R6 dst passthrough", 32'(out_dst[3*TW +: TW]), 4);
    check("R6 op passthrough", 32'(out_op[2*4 +: 4]), 2);
    check("R7 lane enables", 32'(wb_en), 32'b11);
    check("R7 lane0 tag", 32'(wb_tag[0 +: TW]), 1);
    check("R7 lane1 tag", 32'(wb_tag[TW +: TW]), 2);
    check("R7 lane1 data", wb_data[XL +: XL], 32'hFFFF_FFF9);
  endtask

  task automatic t_ops();
    clear_group();
    put(0, 4'd7, 32'h8000_0000, 4, 1, 1, 0, 0, 0, 7'd10);
    put(1, 4'd8, 32'hFFFF_FFFF, 1, 1, 1, 0, 0, 0, 7'd11);
    step();
    check("R2 sra", res_of(0), 32'hF800_0000);
    check("R2 slt signed", res_of(1), 1);
    clear_group();
    put(0, 4'd9, 32'hFFFF_FFFF, 1, 1, 1, 0, 0, 0, 7'd12);
    put(1, 4'd10, 32'h1000, 32'h20, 1, 0, 1, 0, 0, 7'd13);
    step();
    check("R2 sltu", res_of(0), 0);
    check("R4 immediate counts ready", 32'(out_done[1]), 1);
    check("R2 address add", res_of(1), 32'h1020);
    clear_group();
    put(0, 4'd5, 1, 31, 1, 1, 0, 0, 0, 7'd14);
    put(1, 4'd6, 32'h8000_0000, 32'h3F, 1, 1, 0, 0, 0, 7'd15);
    step();
    check("R2 sll", res_of(0), 32'h8000_0000);
    check("R2 srl low bits only", res_of(1), 1);
    clear_group();
    put(0, 4'd3, 32'hF0, 32'h0F, 1, 1, 0, 0, 0, 7'd16);
    put(2, 4'd4, 32'hFF, 32'h0F, 1, 1, 0, 0, 0, 7'd17);
    step();
    check("R2 or", res_of(0), 32'hFF);
    check("R2 xor", res_of(2), 32'hF0);
    check("R7 second lane from slot 2", 32'(wb_tag[TW +: TW]), 17);
  endtask

  task automatic t_noncand();
    clear_group();
    put(0, 4'd12, 1, 1, 1, 1, 0, 0, 0, 7'd20);
    put(1, 4'd0, 1, 1, 1, 1, 0, 0, 0, 7'd21);
    in_valid[1] = 1'b0;
    put(2, 4'd0, 1, 1, 0, 1, 0, 7'd99, 0, 7'd22);
    put(3, 4'd0, 2, 2, 1, 1, 0, 0, 0, 7'd23);
    step();
    check("R1 non-candidate not done", 32'(out_done[0]), 0);
    check("R9 invalid slot", 32'(out_valid[1]) | 32'(out_done[1]), 0);
    check("R3 missing operand not done", 32'(out_done[2]), 0);
    check("R5 later slot gets ALU", 32'(out_done[3]), 1);
    check("R7 single lane", 32'(wb_en), 32'b01);
    check("R6 unexecuted result zero", res_of(0), 0);
  endtask

  task automatic t_bypass();
    clear_group();
    put(0, 4'd0, 5, 7, 1, 1, 0, 0, 0, 7'd5);
    step();
    clear_group();
    put(0, 4'd0, 0, 3, 0, 1, 0, 7'd5, 0, 7'd9);
    put(1, 4'd0, 0, 0, 0, 0, 0, 7'd5, 7'd5, 7'd40);
    put(2, 4'd1, 20, 0, 1, 0, 0, 0, 7'd5, 7'd41);
    step();
    check("R4 bypass operand A", 32'(out_done[0]), 1);
    check("R4 bypassed result", res_of(0), 15);
    check("R3 two missing not done", 32'(out_done[1]), 0);
    check("R4 bypass operand B", res_of(2), 8);
    clear_group();
    put(0, 4'd0, 0, 1, 0, 1, 0, 7'd5, 0, 7'd42);
    step();
    check("R4 older group not bypassed", 32'(out_done[0]), 0);
    clear_group();
    put(0, 4'd0, 1, 1, 1, 1, 0, 0, 0, 7'd7);
    step();
    clear_group();
    step();
    put(0, 4'd0, 0, 1, 0, 1, 0, 7'd7, 0, 7'd43);
    step();
    check("R4 bubble breaks bypass", 32'(out_done[0]), 0);
  endtask

  task automatic t_fwd_pass();
    clear_group();
    put(0, 4'd0, 90, 10, 1, 1, 0, 0, 0, 7'd50);
    step();
    clear_group();
    put(0, 4'd0, 1, 1, 1, 1, 0, 0, 0, 7'd51);
    put(1, 4'd0, 2, 2, 1, 1, 0, 0, 0, 7'd52);
    put(2, 4'd0, 0, 4, 0, 1, 0, 7'd50, 0, 7'd53);
    step();
    check("R5 no ALU left for slot 2", 32'(out_done), 32'b0011);
    check("R10 forwarded value", out_a[2*XL +: XL], 100);
    check("R10 ready set", 32'(out_rdy_a[2]), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alloc();
    t_ops();
    t_noncand();
    t_bypass();
    t_fwd_pass();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule